// File: doc/BRIEF.md
# Exception Cause and Vector Generator

This block turns a one-cycle exception request into everything a processor core needs to enter a handler. From the kind of exception, the exception base address and a few status and configuration bits, it produces the 5-bit cause code, the handler entry address, the resume address, the branch-delay marker and the pulses that tell the core to update its exception PC and set its exception-level bit. All results are registered and appear one cycle after the request.

The handler address is a base plus an offset. The base depends on the bootstrap flag and on whether the exception is a cache error, which is sent to the uncached kernel segment. The offset depends on the kind of exception: a fast TLB-refill slot, a general slot, an interrupt slot that can be spread out by a vector spacing times the number of the highest-priority enabled interrupt, and a cache-error slot. The core supplies the delay-slot flag and the current PC, and it applies the register updates when the pulses come out. Debug entry and reset entry are handled elsewhere.

Top module: `exc_vector_gen`

## Requirements
- R1: `exc_kind` selects the cause code placed on `out_cause`. The mapping is 0 interrupt→0, 1 modify→1, 2 TLB load→2, 3 TLB store→3, 4 address load→4, 5 address store→5, 6 syscall→8, 7 break→9, 8 reserved instruction→10, 9 coprocessor unusable→11, 10 overflow→12, 11 trap→13, 12 read-inhibit→19, 13 execute-inhibit→20, 14 cache error→30. The unused kind 15 reports 10.
- R2: `out_valid` is high for exactly the cycle after each cycle in which `exc_req` is high and is low otherwise. After reset all outputs are zero.
- R3: When `status_bev` is clear, the base is `exc_base` with bits 11:0 cleared. Kinds other than interrupt, TLB refill and cache error add offset 0x180.
- R4: A TLB load or store (kind 2 or 3) with `tlb_nomatch` high and `status_exl` clear uses offset 0x000. With `status_exl` set or `tlb_nomatch` low it uses 0x180.
- R5: An interrupt uses offset 0x200 when `vec_int_en` is low, when `status_bev` is set or when `vec_spacing` is zero.
- R6: Otherwise an interrupt uses offset 0x200 + n × (`vec_spacing` × 32), where n is the index of the highest set bit of `int_pending & int_mask`, or 0 if none is set.
- R7: When `status_bev` is set, the base is `exc_base` + 0x200 for every kind, cache errors included.
- R8: A cache error uses offset 0x100. With `status_bev` and `cache_base_keep` clear, its base is 0xA000_0000 OR (`exc_base` & 0x1FFF_F000). With `cache_base_keep` set, it uses the R3 base.
- R9: If `status_exl` is clear at the request, `out_epc_we` and `out_set_exl` pulse with `out_valid`, `out_epc` is `cur_pc` − 4 when `in_delay_slot` is high and `cur_pc` otherwise, and `out_bd` equals `in_delay_slot`. If `status_exl` is set, both pulses stay low and `out_bd` is 0.
- R10: `out_cause` is rewritten on every request, whatever `status_exl` is, and holds its value in cycles without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | One-cycle exception request |
| exc_kind | input | 4 | Exception kind (encoding in R1) |
| tlb_nomatch | input | 1 | TLB access found no matching entry |
| in_delay_slot | input | 1 | Faulting instruction sits in a branch delay slot |
| cur_pc | input | 32 | PC of the faulting instruction |
| status_exl | input | 1 | Exception level already active |
| status_bev | input | 1 | Bootstrap vectors selected |
| vec_int_en | input | 1 | Vectored interrupts enabled |
| int_pending | input | 8 | Pending interrupt lines |
| int_mask | input | 8 | Interrupt enable mask |
| vec_spacing | input | 5 | Vector spacing in units of 32 bytes |
| exc_base | input | 32 | Exception base address |
| cache_base_keep | input | 1 | Keep cache errors on the normal base |
| out_valid | output | 1 | Results valid |
| out_cause | output | 5 | Cause code for the cause register |
| out_handler | output | 32 | Handler entry address |
| out_epc_we | output | 1 | Write the exception PC |
| out_epc | output | 32 | Resume address to write |
| out_bd | output | 1 | Branch-delay bit to write |
| out_set_exl | output | 1 | Set the exception-level bit |

## Verification
The assertions check on every cycle that a result follows each request by exactly one cycle, that the exception level blocks or enables the EPC and EXL pulses, that cause codes hold between requests, that the refill slot lands on a 4 KiB boundary, that cache errors land in the uncached segment, and that the interrupt encoder picks the highest enabled line. The exact handler addresses need the bench's scenarios: spacing products, masked pending patterns, the bootstrap base, cache-base override and the full cause table. The same holds for the EPC adjustment in delay slots.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;

    localparam int ADDR_W = 32;
    localparam int CODE_W = 5;
    localparam int KIND_W = 4;

    typedef enum logic [KIND_W-1:0] {
        EK_INT    = 4'd0,
        EK_MOD    = 4'd1,
        EK_TLBL   = 4'd2,
        EK_TLBS   = 4'd3,
        EK_ADEL   = 4'd4,
        EK_ADES   = 4'd5,
        EK_SYS    = 4'd6,
        EK_BRK    = 4'd7,
        EK_RSVD   = 4'd8,
        EK_CPU    = 4'd9,
        EK_OVF    = 4'd10,
        EK_TRAP   = 4'd11,
        EK_RDINH  = 4'd12,
        EK_EXINH  = 4'd13,
        EK_CACHE  = 4'd14
    } exc_kind_e;

    localparam logic [ADDR_W-1:0] OFS_REFILL  = 32'h0000_0000;
    localparam logic [ADDR_W-1:0] OFS_CACHE   = 32'h0000_0100;
    localparam logic [ADDR_W-1:0] OFS_GENERAL = 32'h0000_0180;
    localparam logic [ADDR_W-1:0] OFS_INTR    = 32'h0000_0200;
    localparam logic [ADDR_W-1:0] BEV_ADD     = 32'h0000_0200;
    localparam logic [ADDR_W-1:0] UNCACHED    = 32'hA000_0000;
    localparam logic [ADDR_W-1:0] CACHE_KEEP  = 32'h1FFF_F000;
    localparam logic [ADDR_W-1:0] BASE_ALIGN  = 32'hFFFF_F000;
    localparam logic [ADDR_W-1:0] INSN_BYTES  = 32'd4;
    localparam int                SPACE_SHIFT = 5;

    typedef struct packed {
        logic              we;
        logic              set_exl;
        logic              bd;
        logic [ADDR_W-1:0] epc;
    } epc_upd_t;

    function automatic logic [CODE_W-1:0] kind_to_code(input logic [KIND_W-1:0] k);
        case (k)
            EK_INT:   return 5'd0;
            EK_MOD:   return 5'd1;
            EK_TLBL:  return 5'd2;
            EK_TLBS:  return 5'd3;
            EK_ADEL:  return 5'd4;
            EK_ADES:  return 5'd5;
            EK_SYS:   return 5'd8;
            EK_BRK:   return 5'd9;
            EK_RSVD:  return 5'd10;
            EK_CPU:   return 5'd11;
            EK_OVF:   return 5'd12;
            EK_TRAP:  return 5'd13;
            EK_RDINH: return 5'd19;
            EK_EXINH: return 5'd20;
            EK_CACHE: return 5'd30;
            default:  return 5'd10;
        endcase
    endfunction

endpackage

// File: rtl/exc_int_prio.sv
module exc_int_prio #(
    parameter int INT_W = 8,
    localparam int IDX_W = (INT_W > 1) ? $clog2(INT_W) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [INT_W-1:0] pending,
    input  logic [INT_W-1:0] mask,
    output logic [IDX_W-1:0] idx
);
    logic [INT_W-1:0] masked;
    assign masked = pending & mask;

    always_comb begin
        idx = '0;
        for (int i = 0; i < INT_W; i++) begin
            if (masked[i]) idx = IDX_W'(i);
        end
    end

    // R6: the chosen line is enabled and no higher enabled line exists
    assert_prio_highest_R6: assert property (@(posedge clk) disable iff (rst)
        (|masked) |-> ((masked >> idx) == INT_W'(1)));
    assert_prio_empty_R6: assert property (@(posedge clk) disable iff (rst)
        (masked == '0) |-> (idx == '0));
endmodule

// File: rtl/exc_vec_offset.sv
module exc_vec_offset
    import exc_vec_pkg::*;
#(
    parameter int SPACE_W = 5,
    parameter int IDX_W   = 3
) (
    input  logic [KIND_W-1:0]  kind,
    input  logic               tlb_nomatch,
    input  logic               exl,
    input  logic               bev,
    input  logic               vec_en,
    input  logic [SPACE_W-1:0] spacing,
    input  logic [IDX_W-1:0]   vec_idx,
    input  logic [ADDR_W-1:0]  exc_base,
    input  logic               cache_keep,
    output logic [ADDR_W-1:0]  handler
);
    logic [ADDR_W-1:0] ofs;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] slot_bytes;

    assign slot_bytes = ADDR_W'(spacing) << SPACE_SHIFT;

    always_comb begin
        case (kind)
            EK_INT: begin
                if (vec_en && !bev && (spacing != '0))
                    ofs = OFS_INTR + ADDR_W'(vec_idx) * slot_bytes;
                else
                    ofs = OFS_INTR;
            end
            EK_TLBL, EK_TLBS: ofs = (tlb_nomatch && !exl) ? OFS_REFILL : OFS_GENERAL;
            EK_CACHE:         ofs = OFS_CACHE;
            default:          ofs = OFS_GENERAL;
        endcase
    end

    always_comb begin
        if (bev)
            base = exc_base + BEV_ADD;
        else if ((kind == EK_CACHE) && !cache_keep)
            base = UNCACHED | (exc_base & CACHE_KEEP);
        else
            base = exc_base & BASE_ALIGN;
    end

    assign handler = base + ofs;
endmodule

// File: rtl/exc_epc_update.sv
module exc_epc_update
    import exc_vec_pkg::*;
(
    input  logic              exl,
    input  logic              in_delay,
    input  logic [ADDR_W-1:0] pc,
    output epc_upd_t          upd
);
    always_comb begin
        upd.we      = !exl;
        upd.set_exl = !exl;
        upd.bd      = !exl && in_delay;
        upd.epc     = in_delay ? (pc - INSN_BYTES) : pc;
    end
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
    import exc_vec_pkg::*;
#(
    parameter int INT_W   = 8,
    parameter int SPACE_W = 5,
    localparam int IDX_W  = (INT_W > 1) ? $clog2(INT_W) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               exc_req,
    input  logic [KIND_W-1:0]  exc_kind,
    input  logic               tlb_nomatch,
    input  logic               in_delay_slot,
    input  logic [ADDR_W-1:0]  cur_pc,
    input  logic               status_exl,
    input  logic               status_bev,
    input  logic               vec_int_en,
    input  logic [INT_W-1:0]   int_pending,
    input  logic [INT_W-1:0]   int_mask,
    input  logic [SPACE_W-1:0] vec_spacing,
    input  logic [ADDR_W-1:0]  exc_base,
    input  logic               cache_base_keep,
    output logic               out_valid,
    output logic [CODE_W-1:0]  out_cause,
    output logic [ADDR_W-1:0]  out_handler,
    output logic               out_epc_we,
    output logic [ADDR_W-1:0]  out_epc,
    output logic               out_bd,
    output logic               out_set_exl
);
    logic [IDX_W-1:0]  vec_idx;
    logic [ADDR_W-1:0] handler_c;
    epc_upd_t          upd_c;

    exc_int_prio #(.INT_W(INT_W)) u_prio (
        .clk     (clk),
        .rst     (rst),
        .pending (int_pending),
        .mask    (int_mask),
        .idx     (vec_idx)
    );

    exc_vec_offset #(.SPACE_W(SPACE_W), .IDX_W(IDX_W)) u_ofs (
        .kind        (exc_kind),
        .tlb_nomatch (tlb_nomatch),
        .exl         (status_exl),
        .bev         (status_bev),
        .vec_en      (vec_int_en),
        .spacing     (vec_spacing),
        .vec_idx     (vec_idx),
        .exc_base    (exc_base),
        .cache_keep  (cache_base_keep),
        .handler     (handler_c)
    );

    exc_epc_update u_epc (
        .exl      (status_exl),
        .in_delay (in_delay_slot),
        .pc       (cur_pc),
        .upd      (upd_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_cause   <= '0;
            out_handler <= '0;
            out_epc_we  <= 1'b0;
            out_epc     <= '0;
            out_bd      <= 1'b0;
            out_set_exl <= 1'b0;
        end else begin
            out_valid   <= exc_req;
            out_epc_we  <= exc_req && upd_c.we;
            out_set_exl <= exc_req && upd_c.set_exl;
            if (exc_req) begin
                out_cause   <= kind_to_code(exc_kind);
                out_handler <= handler_c;
                out_epc     <= upd_c.epc;
                out_bd      <= upd_c.bd;
            end
        end
    end

    assert_valid_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
        exc_req |=> out_valid);
    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (rst)
        !exc_req |=> !out_valid);
    assert_exl_blocks_update_R9: assert property (@(posedge clk) disable iff (rst)
        (exc_req && status_exl) |=> (!out_epc_we && !out_set_exl && !out_bd));
    assert_exl_clear_update_R9: assert property (@(posedge clk) disable iff (rst)
        (exc_req && !status_exl) |=> (out_epc_we && out_set_exl));
    assert_cause_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !exc_req |=> $stable(out_cause));
    assert_refill_aligned_R4: assert property (@(posedge clk) disable iff (rst)
        (exc_req && ((exc_kind == EK_TLBL) || (exc_kind == EK_TLBS)) && tlb_nomatch
         && !status_exl && !status_bev) |=> (out_handler[11:0] == 12'h000));
    assert_cache_uncached_R8: assert property (@(posedge clk) disable iff (rst)
        (exc_req && (exc_kind == EK_CACHE) && !status_bev && !cache_base_keep)
        |=> (out_handler[31:29] == 3'b101));
endmodule

// File: tb/tb_exc_vector_gen.sv
`timescale 1ns/1ps
module tb_exc_vector_gen;

    typedef struct packed {
        logic [3:0]  kind;
        logic        nm;
        logic        exl;
        logic        bev;
        logic        dly;
        logic        ven;
        logic        keep;
        logic [7:0]  pend;
        logic [7:0]  mask;
        logic [4:0]  sp;
        logic [31:0] base;
        logic [4:0]  cause;
        logic [31:0] hand;
    } vec_t;

    localparam logic [31:0] B  = 32'h8000_1234;
    localparam logic [31:0] B2 = 32'h9234_5678;
    localparam int NV = 28;

    localparam vec_t TBL [NV] = '{
        '{4'd6,  1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00,8'h00,5'd0,  B,  5'd8,  32'h8000_1180}, // R1 R3
        '{4'd2,  1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 8'h00,8'h00,5'd0,  B,  5'd2,  32'h8000_1000}, // R4
        '{4'd3,  1'b1,1'b1,1'b0,1'b1,1'b0,1'b0, 8'h00,8'h00,5'd0,  B,  5'd3,  32'h8000_1180}, // R4 exl set
        '{4'd2,  1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00,8'h00,5'd0,  B,  5'd2,  32'h8000_1180}, // R4 match
        '{4'd3,  1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00,8'h00,5'd0,  B,  5'd3,  32'h8000_1000}, // R4
        '{4'd0,  1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'hFF,8'hFF,5'd3,  B,  5'd0,  32'h8000_1200}, // R5
        '{4'd0,  1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 8'h24,8'hFF,5'd1,  B,  5'd0,  32'h8000_12A0}, // R6
        '{4'd0,  1'b0,1'b0,1'b0,1'b1,1'b1,1'b0, 8'hA0,8'h3F,5'd2,  B,  5'd0,  32'h8000_1340}, // R6 mask
        '{4'd0,  1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 8'hFF,8'hFF,5'd0,  B,  5'd0,  32'h8000_1200}, // R5 sp0
        '{4'd0,  1'b0,1'b0,1'b1,1'b0,1'b1,1'b0, 8'hFF,8'hFF,5'd1,  B,  5'd0,  32'h8000_1634}, // R5 R7
        '{4'd0,  1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 8'h0F,8'hF0,5'd4,  B,  5'd0,  32'h8000_1200}, // R6 none
        '{4'd14, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00,8'h00,5'd0,  B2, 5'd30, 32'hB234_5100}, // R8
        '{4'd14, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 8'h00,8'h00,5'd0,  B2, 5'd30, 32'h9234_5100}, // R8 keep
        '{4'd14, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 8'h00,8'h00,5'd0,  B2, 5'd30, 32'h9234_5978}, // R7 R8
        '{4'd13, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 8'h00,8'h00,5'd0,  B,  5'd20, 32'h8000_1180}, // R1
        '{4'd12, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00,8'h00,5'd0,  B,  5'd19, 32'h8000_1180},
        '{4'd1,  1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00,8'h00,5'd0,  B,  5'd1,  32'h8000_1180},
        '{4'd4,  1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00,8'h00,5'd0,  B,  5'd4,  32'h8000_1180},
        '{4'd5,  1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 8'h00,8'h00,5'd0,  B,  5'd5,  32'h8000_1180},
        '{4'd7,  1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00,8'h00,5'd0,  B,  5'd9,  32'h8000_1180},
        '{4'd8,  1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00,8'h00,5'd0,  B,  5'd10, 32'h8000_1180},
        '{4'd9,  1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00,8'h00,5'd0,  B,  5'd11, 32'h8000_1180},
        '{4'd10, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00,8'h00,5'd0,  B,  5'd12, 32'h8000_1180},
        '{4'd11, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00,8'h00,5'd0,  B,  5'd13, 32'h8000_1180},
        '{4'd15, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00,8'h00,5'd0,  B,  5'd10, 32'h8000_1180},
        '{4'd6,  1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 8'h00,8'h00,5'd0,  B,  5'd8,  32'h8000_15B4}, // R7
        '{4'd0,  1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 8'h80,8'h80,5'd31, B,  5'd0,  32'h8000_2D20}, // R6 max
        '{4'd2,  1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 8'h00,8'h00,5'd0,  B,  5'd2,  32'h8000_1434}  // R4 R7
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exc_req = 1'b0;
    logic [3:0]  exc_kind = '0;
    logic        tlb_nomatch = 1'b0;
    logic        in_delay_slot = 1'b0;
    logic [31:0] cur_pc = '0;
    logic        status_exl = 1'b0;
    logic        status_bev = 1'b0;
    logic        vec_int_en = 1'b0;
    logic [7:0]  int_pending = '0;
    logic [7:0]  int_mask = '0;
    logic [4:0]  vec_spacing = '0;
    logic [31:0] exc_base = '0;
    logic        cache_base_keep = 1'b0;
    logic        out_valid;
    logic [4:0]  out_cause;
    logic [31:0] out_handler;
    logic        out_epc_we;
    logic [31:0] out_epc;
    logic        out_bd;
    logic        out_set_exl;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    exc_vector_gen dut (
        .clk(clk), .rst(rst), .exc_req(exc_req), .exc_kind(exc_kind),
        .tlb_nomatch(tlb_nomatch), .in_delay_slot(in_delay_slot), .cur_pc(cur_pc),
        .status_exl(status_exl), .status_bev(status_bev), .vec_int_en(vec_int_en),
        .int_pending(int_pending), .int_mask(int_mask), .vec_spacing(vec_spacing),
        .exc_base(exc_base), .cache_base_keep(cache_base_keep),
        .out_valid(out_valid), .out_cause(out_cause), .out_handler(out_handler),
        .out_epc_we(out_epc_we), .out_epc(out_epc), .out_bd(out_bd),
        .out_set_exl(out_set_exl)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic fire(input vec_t v, input logic [31:0] pc);
        @(negedge clk);
        exc_kind = v.kind; tlb_nomatch = v.nm; status_exl = v.exl; status_bev = v.bev;
        in_delay_slot = v.dly; vec_int_en = v.ven; cache_base_keep = v.keep;
        int_pending = v.pend; int_mask = v.mask; vec_spacing = v.sp;
        exc_base = v.base; cur_pc = pc; exc_req = 1'b1;
        @(negedge clk);
        exc_req = 1'b0;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R2: reset state
        chk("R2", "valid after reset", 32'(out_valid), 32'd0);
        chk("R2", "handler after reset", out_handler, 32'd0);
        chk("R2", "cause after reset", 32'(out_cause), 32'd0);
        chk("R2", "pulses after reset", {30'd0, out_epc_we, out_set_exl}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [31:0] pc;
            logic [31:0] exp_epc;
            pc = 32'h0040_0100 + 32'(i) * 32'd16;
            exp_epc = TBL[i].dly ? pc - 32'd4 : pc;
            fire(TBL[i], pc);
            chk("R2", "valid", 32'(out_valid), 32'd1);
            chk("R1", "cause", 32'(out_cause), 32'(TBL[i].cause));
            chk("R3-R8 handler", "handler", out_handler, TBL[i].hand);
            chk("R9", "epc_we/set_exl/bd",
                {29'd0, out_epc_we, out_set_exl, out_bd},
                {29'd0, !TBL[i].exl, !TBL[i].exl, !TBL[i].exl && TBL[i].dly});
            if (!TBL[i].exl)
                chk("R9", "epc", out_epc, exp_epc);
        end

        // R2: valid drops the cycle after the result; R10: cause holds without request
        @(negedge clk);
        exc_kind = 4'd14;
        chk("R2", "valid low when idle", 32'(out_valid), 32'd0);
        @(negedge clk);
        chk("R10", "cause held", 32'(out_cause), 32'd2);
        chk("R9", "pulses low when idle", {30'd0, out_epc_we, out_set_exl}, 32'd0);

        // R10: cause rewritten even while EXL is set
        fire('{4'd7, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h00,8'h00,5'd0, B, 5'd9, 32'h8000_1180},
             32'h0000_2000);
        chk("R10", "cause with exl set", 32'(out_cause), 32'd9);
        chk("R9", "epc_we with exl set", 32'(out_epc_we), 32'd0);

        // R2: back-to-back requests give back-to-back results
        @(negedge clk);
        exc_kind = 4'd8; status_exl = 1'b0; exc_req = 1'b1;
        @(negedge clk);
        exc_kind = 4'd9;
        chk("R2", "first of pair valid", 32'(out_valid), 32'd1);
        chk("R1", "first of pair cause", 32'(out_cause), 32'd10);
        @(negedge clk);
        exc_req = 1'b0;
        chk("R2", "second of pair valid", 32'(out_valid), 32'd1);
        chk("R1", "second of pair cause", 32'(out_cause), 32'd11);
        @(negedge clk);
        chk("R2", "valid low after pair", 32'(out_valid), 32'd0);

        // R2: reset clears outputs mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R2", "cause after second reset", 32'(out_cause), 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule